// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates a set of Boolean functions of a few inputs as sums of products. The functions are chosen by configuration registers, not by the hardware. A product-term array ANDs together the literals chosen for each term. A literal is an input in its true form or in its inverted form. A sum array then ORs the chosen terms into each output, and each output can be inverted. One product term may drive any number of outputs, so common sub-expressions are built once.

A mode pin turns off the programmable sum selection. Output `o` then collects only its own dedicated block of consecutive product terms. In that mode the block behaves as an array-logic device: the product terms stay programmable, but the wiring into each output is fixed.

The configuration is written one word per clock through an address/data port. The data path from `pin_in` to `pin_out` has no register in it, so the outputs follow the inputs and the mode pin within the same cycle.

Top module: `pla_core`

## Requirements
- R1: After reset every configuration word is zero, so `pin_out` is all zero for every input value and for both modes.
- R2: A write with `cfg_we` high to address t, where t < N_TERM, loads the literal mask of product term t. Data bit 2i connects input i in true form and bit 2i+1 connects input i in inverted form. The new mask is in effect once that clock edge has passed.
- R3: A write to address N_TERM+o loads the sum row of output o. Data bits [N_TERM-1:0] select the terms that feed the output, and data bit N_TERM inverts the output.
- R4: A write to an address at or above N_TERM+N_OUT, or any cycle with `cfg_we` low, leaves every output function unchanged.
- R5: A product term is 1 exactly when all of its connected literals are 1. An input with neither of its literals connected does not affect the term.
- R6: A product term with no connected literal is 0.
- R7: A product term that connects both the true and the inverted literal of the same input is always 0.
- R8: In programmable mode (`or_fixed`=0), output o is the OR of its selected terms, XORed with its invert bit. A single term may feed several outputs at once.
- R9: In fixed mode (`or_fixed`=1), output o is the OR of terms o*G to o*G+G-1, where G = N_TERM/N_OUT, XORed with its invert bit. The term-select bits are ignored.
- R10: `pin_out` responds to changes on `pin_in` and `or_fixed` with no clock edge in between.
- R11: With 4 terms (AB, AC, BC, A'B'C') over A=`pin_in[2]`, B=`pin_in[1]`, C=`pin_in[0]`, the shared terms realise two functions. Output 0 is the inverted OR of the first three terms, which gives minterms 0, 1, 2 and 4. Output 1 is the OR of AB, AC and A'B'C', which gives minterms 0, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Word address: terms first, then output rows |
| cfg_data | input | CFG_W | Configuration word |
| or_fixed | input | 1 | 1 = dedicated term groups per output |
| pin_in | input | N_IN | Logic inputs |
| pin_out | output | N_OUT | Logic outputs |

## Verification
The bench goes after four corner cases, and each one has a visible failure mode.

- **Blank term:** a term whose mask is blank must not act as an always-true term. A design that got this wrong would force every output that selects the term to 1.
- **Self-contradicting term:** a term that connects both literals of one input must read 0. A design that took the OR of the literals, or that wired one literal into both lanes, would let such a term leak through.
- **Fixed mode:** this mode must draw on the proper term group and ignore the select bits. A design with the groups off by one would show the wrong function of B and C.
- **Out-of-range writes:** these must leave the configuration alone. A design that decoded too few address bits would corrupt a term and change the shared-term example functions.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic {
        SUM_PROGRAMMED = 1'b0,
        SUM_DEDICATED  = 1'b1
    } sum_mode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int group_size(input int terms, input int outs);
        return imax(1, terms / outs);
    endfunction

endpackage

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    parameter int CFG_W  = 6,
    parameter int ADDR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [CFG_W-1:0]                 data,
    output logic [N_TERM-1:0][2*N_IN-1:0]    and_mask,
    output logic [N_OUT-1:0][N_TERM-1:0]     or_mask,
    output logic [N_OUT-1:0]                 or_inv
);
    localparam int LIT_W  = 2 * N_IN;
    localparam int N_WORD = N_TERM + N_OUT;

    typedef struct packed {
        logic [N_TERM-1:0][LIT_W-1:0]  lits;
        logic [N_OUT-1:0][N_TERM-1:0]  sel;
        logic [N_OUT-1:0]              inv;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int t = 0; t < N_TERM; t++) begin
                if (int'(addr) == t) st_d.lits[t] = data[LIT_W-1:0];
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (int'(addr) == N_TERM + o) begin
                    st_d.sel[o] = data[N_TERM-1:0];
                    st_d.inv[o] = data[N_TERM];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign and_mask = st_q.lits;
    assign or_mask  = st_q.sel;
    assign or_inv   = st_q.inv;

    // R2: a term write lands in the addressed row
    p_term_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) < N_TERM) |=>
            and_mask[$past(addr)] == $past(data[LIT_W-1:0]));

    // R3: an output-row write lands in select and invert
    p_row_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) >= N_TERM && int'(addr) < N_WORD) |=>
            {or_inv[$past(addr) - ADDR_W'(N_TERM)], or_mask[$past(addr) - ADDR_W'(N_TERM)]}
                == $past(data[N_TERM:0]));

    // R4: idle cycles and out-of-range writes keep the configuration
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || int'(addr) >= N_WORD) |=>
            ($stable(and_mask) && $stable(or_mask) && $stable(or_inv)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4
) (
    input  logic [N_IN-1:0]               pin_in,
    input  logic [N_TERM-1:0][2*N_IN-1:0] and_mask,
    output logic [N_TERM-1:0]             term
);
    localparam int LIT_W = 2 * N_IN;

    logic [LIT_W-1:0] lits;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = pin_in[i];
            lits[2*i+1] = ~pin_in[i];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic used;
        assign used    = |and_mask[t];
        assign term[t] = used & (&(lits | ~and_mask[t]));
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2
) (
    input  logic [N_TERM-1:0]             term,
    input  logic [N_OUT-1:0][N_TERM-1:0]  or_mask,
    input  logic [N_OUT-1:0]              or_inv,
    input  sum_mode_e                     mode,
    output logic [N_OUT-1:0]              pin_out
);
    localparam int GRP = group_size(N_TERM, N_OUT);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] grp_mask;
        logic [N_TERM-1:0] pick;

        always_comb begin
            for (int t = 0; t < N_TERM; t++) begin
                grp_mask[t] = (t / GRP) == o;
            end
        end

        assign pick       = (mode == SUM_DEDICATED) ? grp_mask : or_mask[o];
        assign pin_out[o] = (|(term & pick)) ^ or_inv[o];
    end

endmodule

// File: rtl/pla_core.sv
module pla_core
    import pla_pkg::*;
#(
    parameter int  N_IN   = 3,
    parameter int  N_TERM = 4,
    parameter int  N_OUT  = 2,
    localparam int CFG_W  = imax(2 * N_IN, N_TERM + 1),
    localparam int ADDR_W = imax(1, $clog2(N_TERM + N_OUT))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              or_fixed,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_OUT-1:0]  pin_out
);
    localparam int GRP = group_size(N_TERM, N_OUT);

    logic [N_TERM-1:0][2*N_IN-1:0] and_mask;
    logic [N_OUT-1:0][N_TERM-1:0]  or_mask;
    logic [N_OUT-1:0]              or_inv;
    logic [N_TERM-1:0]             term;
    sum_mode_e                     mode;

    assign mode = sum_mode_e'(or_fixed);

    pla_cfg_regs #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .CFG_W(CFG_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
        .and_mask(and_mask), .or_mask(or_mask), .or_inv(or_inv)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .pin_in(pin_in), .and_mask(and_mask), .term(term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term(term), .or_mask(or_mask), .or_inv(or_inv), .mode(mode), .pin_out(pin_out)
    );

    for (genvar t = 0; t < N_TERM; t++) begin : g_chk_term
        logic clash;
        always_comb begin
            clash = 1'b0;
            for (int i = 0; i < N_IN; i++) begin
                clash = clash | (and_mask[t][2*i] & and_mask[t][2*i+1]);
            end
        end

        // R6: a blank term never fires
        p_blank_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (and_mask[t] == '0) |-> !term[t]);

        // R7: a term with both polarities of one input never fires
        p_clash_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clash |-> !term[t]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk_out
        logic [N_TERM-1:0] own;
        always_comb begin
            for (int t = 0; t < N_TERM; t++) own[t] = (t / GRP) == o;
        end

        // R8: any selected active term drives the output to its active level
        p_sum_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!or_fixed && |(term & or_mask[o])) |-> (pin_out[o] == !or_inv[o]));

        // R9: in dedicated mode only the own group can raise the output
        p_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (or_fixed && !(|(term & own))) |-> (pin_out[o] == or_inv[o]));
    end

endmodule

// File: tb/sim_pla_core.sv
module sim_pla_core;
    localparam int N_IN   = 3;
    localparam int N_TERM = 4;
    localparam int N_OUT  = 2;
    localparam int CFG_W  = 6;
    localparam int ADDR_W = 3;
    localparam int GRP    = N_TERM / N_OUT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_data = '0;
    logic              or_fixed = 1'b0;
    logic [N_IN-1:0]   pin_in = '0;
    logic [N_OUT-1:0]  pin_out;

    always #10 clk = ~clk;

    pla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .or_fixed(or_fixed), .pin_in(pin_in), .pin_out(pin_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench shadow of the configuration, kept from the requirements
    logic [2*N_IN-1:0] sh_and [N_TERM];
    logic [N_TERM-1:0] sh_sel [N_OUT];
    logic              sh_inv [N_OUT];

    typedef struct {
        logic [N_OUT-1:0] exp;
        string            tag;
    } item_t;
    item_t sb[$];

    function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x, input logic fx);
        logic [N_TERM-1:0] tm;
        logic [N_OUT-1:0]  r;
        for (int t = 0; t < N_TERM; t++) begin
            tm[t] = (sh_and[t] != '0);
            for (int i = 0; i < N_IN; i++) begin
                if (sh_and[t][2*i]   && !x[i]) tm[t] = 1'b0;
                if (sh_and[t][2*i+1] &&  x[i]) tm[t] = 1'b0;
            end
        end
        for (int o = 0; o < N_OUT; o++) begin
            logic acc;
            acc = 1'b0;
            for (int t = 0; t < N_TERM; t++) begin
                if (fx ? (t >= o*GRP && t < (o+1)*GRP) : sh_sel[o][t]) acc = acc | tm[t];
            end
            r[o] = acc ^ sh_inv[o];
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic drive(input logic [N_IN-1:0] x, input logic fx,
                         input logic [N_OUT-1:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        pin_in   = x;
        or_fixed = fx;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic cfg_write(input int a, input logic [CFG_W-1:0] d);
        wait (sb.size() == 0);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = ADDR_W'(a);
        cfg_data = d;
        if (a < N_TERM) sh_and[a] = d[2*N_IN-1:0];
        else if (a < N_TERM + N_OUT) begin
            sh_sel[a-N_TERM] = d[N_TERM-1:0];
            sh_inv[a-N_TERM] = d[N_TERM];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep(input logic fx, input string tag);
        for (int x = 0; x < (1 << N_IN); x++) drive(N_IN'(x), fx, model(N_IN'(x), fx), tag);
    endtask

    // monitor: compare away from the edge that sampled the driven item
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (pin_out !== it.exp) begin
                    errors++;
                    $display("FAIL %s: pin_in=%b mode=%b actual=%b expected=%b",
                             it.tag, pin_in, or_fixed, pin_out, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    localparam logic [7:0] F1_TT = 8'b0001_0111;
    localparam logic [7:0] F2_TT = 8'b1110_0001;

    initial begin
        for (int t = 0; t < N_TERM; t++) sh_and[t] = '0;
        for (int o = 0; o < N_OUT; o++) begin sh_sel[o] = '0; sh_inv[o] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared configuration gives zeros in both modes
        for (int x = 0; x < 8; x++) drive(N_IN'(x), 1'b0, 2'b00, "R1");
        for (int x = 0; x < 8; x++) drive(N_IN'(x), 1'b1, 2'b00, "R1");

        // R2 R3 R11: shared-term example, A=bit2 B=bit1 C=bit0
        cfg_write(0, 6'b010100);   // AB
        cfg_write(1, 6'b010001);   // AC
        cfg_write(2, 6'b000101);   // BC
        cfg_write(3, 6'b101010);   // A'B'C'
        cfg_write(4, 6'b010111);   // out0 = ~(AB+AC+BC)
        cfg_write(5, 6'b001011);   // out1 = AB+AC+A'B'C'
        for (int x = 0; x < 8; x++)
            drive(N_IN'(x), 1'b0, {F2_TT[x], F1_TT[x]}, "R11");
        sweep(1'b0, "R8");

        // R9: dedicated groups {0,1} and {2,3}
        sweep(1'b1, "R9");

        // R10: output follows the input without a clock edge
        wait (sb.size() == 0);
        @(negedge clk);
        or_fixed = 1'b0;
        for (int x = 0; x < 8; x++) begin
            pin_in = N_IN'(x);
            #1;
            checks++;
            if (pin_out !== {F2_TT[x], F1_TT[x]}) begin
                errors++;
                $display("FAIL R10: actual=%b expected=%b", pin_out, {F2_TT[x], F1_TT[x]});
            end
        end

        // R4: out-of-range writes and idle strobes change nothing
        cfg_write(6, 6'b111111);
        cfg_write(7, 6'b111111);
        @(negedge clk);
        cfg_addr = 3'd0;
        cfg_data = 6'b111111;
        repeat (2) @(negedge clk);
        for (int x = 0; x < 8; x++)
            drive(N_IN'(x), 1'b0, {F2_TT[x], F1_TT[x]}, "R4");

        // R7: BC replaced by C and C' together
        cfg_write(2, 6'b000011);
        sweep(1'b0, "R7");

        // R6: blank AB term; R5: term A' alone ignores B and C
        cfg_write(0, 6'b000000);
        cfg_write(3, 6'b100000);
        sweep(1'b0, "R6");
        sweep(1'b1, "R5");

        // R5: term B' feeding both outputs
        cfg_write(1, 6'b001000);
        cfg_write(4, 6'b000010);
        cfg_write(5, 6'b000010);
        for (int x = 0; x < 8; x++)
            drive(N_IN'(x), 1'b0, x[1] ? 2'b00 : 2'b11, "R5");

        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule